// File: doc/BRIEF.md
# Condition-Field Mask-Logic Unit

This block is a combinational execution unit for a small family of condition-field instructions. It reads an eight-entry file of 4-bit condition fields and a 64-bit integer operand. A two-bit selector picks the operation. In every form, each bit of a condition field is compared against a mode bit, and the comparison only counts where the mask bit is set. The per-bit results are then reduced to one bit, written back as a whole field, or used to write a single condition bit. This lets one operation combine several bits of a field, where the usual condition-bit instructions act on only one bit at a time.

The unit holds no state. It presents per-bit write enables and write data for the condition-field file, and a write enable and data for the integer destination. The surrounding pipeline applies these in the same cycle. The field-writing forms can either keep the old destination bits where the mask is clear (read-modify-write) or clear them. A masked-move form copies a field under the mask and then inverts bits selected by mode.

Top module: `crml_unit`

## Requirements
- R1: For each bit index i of a field, the term is t_i = mask[i] AND (mode[i] == source bit i). Bit index 0 is the less-than bit, 1 greater-than, 2 equal, 3 overflow, and mask and mode bits follow the same index order. Field f occupies bits 4f+3..4f of `cr_in`, `cr_we` and `cr_wd`.
- R2: With `op_sel` = 00 (field to integer), the source field's terms are ORed when `merge_m` = 1 and ANDed when `merge_m` = 0. The result goes to bit 0 of `int_wd`, bits 63..1 are zero, and `int_we` = 1.
- R3: With `op_sel` = 00 and `rc` = 1, field 0 is also written. Its less-than, greater-than and equal bits come from a signed compare of the integer result against zero, and its overflow bit is 0. With `rc` = 0, no condition bit is written.
- R4: With `op_sel` = 01 (integer to field), every term compares against bit 0 of `int_src`. That bit is taken as 0 when `int_idx` = 0. The terms form the new field at `dst_fld`.
- R5: In the field-writing forms (01, and 11 with `rc` = 0), `merge_m` = 1 keeps the old destination bit wherever mask is 0, and `merge_m` = 0 writes 0 there.
- R6: With `op_sel` = 11 and `rc` = 0 (field logic), the new field at `dst_fld` is the term vector of field `src_fld`, merged as in R5.
- R7: With `op_sel` = 11 and `rc` = 1 (masked move), the new field is (mask AND source field), ORed with (old destination AND NOT mask) when `merge_m` = 1, and the whole result is then XORed with mode.
- R8: With `op_sel` = 10 (field to single bit), exactly one condition bit is written: field `tgt_bit[4:2]`, bit index `tgt_bit[1:0]`. Its value is the OR (`merge_m` = 1) or AND (`merge_m` = 0) of the source field's terms.
- R9: `int_we` is 1 only for `op_sel` = 00. Forms 01 and 11 enable exactly the four bits of field `dst_fld`, and no other condition bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation selector (instruction bits 19,20) |
| merge_m | input | 1 | Reduction choice / merge flag |
| mask | input | 4 | Per-bit mask |
| mode | input | 4 | Per-bit mode (compare value or inversion) |
| rc | input | 1 | Record / move-form bit |
| src_fld | input | 3 | Source field index |
| dst_fld | input | 3 | Destination field index |
| tgt_bit | input | 5 | Single-bit target: field in [4:2], bit in [1:0] |
| int_idx | input | 5 | Integer register index (0 forces source LSB to 0) |
| int_src | input | 64 | Integer operand |
| cr_in | input | 32 | Current condition-field file, field f in bits 4f+3..4f |
| cr_we | output | 32 | Per-bit condition write enables |
| cr_wd | output | 32 | Condition write data (valid where enabled) |
| int_we | output | 1 | Integer destination write enable |
| int_wd | output | 64 | Integer destination write data |

## Verification
The hardest case to reach from the ports is a read-modify-write where the source and destination are different fields and the old destination bits differ from both the source bits and the mode bits. Only then does a lost or wrongly chosen merge show up in the output. The stimulus fills the field file with distinct nibbles so that every field differs from every other. Directed cases then pair masks that have clear bits with both settings of the merge flag. A pseudorandom sweep over all selectors, indices and target bits covers the rest of the decode.

// File: rtl/crml_pkg.sv
package crml_pkg;
   typedef enum logic [1:0] {
      OP_F2I = 2'b00,
      OP_I2F = 2'b01,
      OP_F2B = 2'b10,
      OP_F2F = 2'b11
   } crml_op_e;

   localparam int BIT_LT = 0;
   localparam int BIT_GT = 1;
   localparam int BIT_EQ = 2;
   localparam int BIT_OV = 3;
endpackage

// File: rtl/crml_terms.sv
module crml_terms #(
   parameter int FIELD_W = 4
) (
   input  logic [FIELD_W-1:0] mask,
   input  logic [FIELD_W-1:0] mode,
   input  logic [FIELD_W-1:0] src,
   output logic [FIELD_W-1:0] terms,
   output logic               any_set,
   output logic               all_set
);
   initial begin
      if (FIELD_W < 1) $error("crml_terms: FIELD_W must be positive");
   end

   for (genvar gi = 0; gi < FIELD_W; gi++) begin : g_bit
      assign terms[gi] = mask[gi] & ~(mode[gi] ^ src[gi]);
   end

   assign any_set = |terms;
   assign all_set = &terms;
endmodule

// File: rtl/crml_merge.sv
module crml_merge #(
   parameter int FIELD_W = 4
) (
   input  logic [FIELD_W-1:0] masked,
   input  logic [FIELD_W-1:0] old_fld,
   input  logic [FIELD_W-1:0] mask,
   input  logic               keep,
   input  logic [FIELD_W-1:0] flip,
   output logic [FIELD_W-1:0] result
);
   logic [FIELD_W-1:0] kept;

   for (genvar gi = 0; gi < FIELD_W; gi++) begin : g_keep
      assign kept[gi] = keep & ~mask[gi] & old_fld[gi];
   end

   assign result = (masked | kept) ^ flip;
endmodule

// File: rtl/crml_unit.sv
module crml_unit
   import crml_pkg::*;
#(
   parameter int NUM_FIELDS = 8,
   parameter int FIELD_W    = 4,
   parameter int XLEN       = 64,
   parameter int REG_IDX_W  = 5,
   parameter bit RC_FLAGS   = 1'b1,
   localparam int FIDX_W    = $clog2(NUM_FIELDS),
   localparam int BIDX_W    = $clog2(FIELD_W),
   localparam int TGT_W     = FIDX_W + BIDX_W,
   localparam int CR_W      = NUM_FIELDS * FIELD_W
) (
   input  logic [1:0]           op_sel,
   input  logic                 merge_m,
   input  logic [FIELD_W-1:0]   mask,
   input  logic [FIELD_W-1:0]   mode,
   input  logic                 rc,
   input  logic [FIDX_W-1:0]    src_fld,
   input  logic [FIDX_W-1:0]    dst_fld,
   input  logic [TGT_W-1:0]     tgt_bit,
   input  logic [REG_IDX_W-1:0] int_idx,
   input  logic [XLEN-1:0]      int_src,
   input  logic [CR_W-1:0]      cr_in,
   output logic [CR_W-1:0]      cr_we,
   output logic [CR_W-1:0]      cr_wd,
   output logic                 int_we,
   output logic [XLEN-1:0]      int_wd
);
   initial begin
      if (FIELD_W != 4) $error("crml_unit: FIELD_W must be 4");
      if ((1 << FIDX_W) != NUM_FIELDS) $error("crml_unit: NUM_FIELDS must be a power of two");
      if (XLEN < 2) $error("crml_unit: XLEN too small");
   end

   crml_op_e op;
   assign op = crml_op_e'(op_sel);

   logic [NUM_FIELDS-1:0][FIELD_W-1:0] file_in, we_a, wd_a;
   assign file_in = cr_in;
   assign cr_we   = we_a;
   assign cr_wd   = wd_a;

   logic [FIELD_W-1:0] src_val, old_val;
   assign src_val = file_in[src_fld];
   assign old_val = file_in[dst_fld];

   // integer-side source bit, forced to zero for register index 0
   logic int_lsb;
   assign int_lsb = (int_idx == '0) ? 1'b0 : int_src[0];

   logic [FIELD_W-1:0] t_fld, t_int;
   logic               any_f, all_f, any_i, all_i;

   crml_terms #(.FIELD_W(FIELD_W)) u_terms_fld (
      .mask(mask), .mode(mode), .src(src_val),
      .terms(t_fld), .any_set(any_f), .all_set(all_f)
   );

   crml_terms #(.FIELD_W(FIELD_W)) u_terms_int (
      .mask(mask), .mode(mode), .src({FIELD_W{int_lsb}}),
      .terms(t_int), .any_set(any_i), .all_set(all_i)
   );

   logic reduced;
   assign reduced = merge_m ? any_f : all_f;

   logic               is_move;
   logic [FIELD_W-1:0] pre_merge, flip_v, new_fld;
   assign is_move   = (op == OP_F2F) && rc;
   assign pre_merge = (op == OP_I2F) ? t_int : (is_move ? (mask & src_val) : t_fld);
   assign flip_v    = is_move ? mode : '0;

   crml_merge #(.FIELD_W(FIELD_W)) u_merge (
      .masked(pre_merge), .old_fld(old_val), .mask(mask),
      .keep(merge_m), .flip(flip_v), .result(new_fld)
   );

   logic [XLEN-1:0]    int_res;
   logic [FIELD_W-1:0] rc_fld;
   assign int_res = {{(XLEN-1){1'b0}}, reduced};

   if (RC_FLAGS) begin : g_rc
      always_comb begin
         rc_fld         = '0;
         rc_fld[BIT_LT] = $signed(int_res) < 0;
         rc_fld[BIT_GT] = $signed(int_res) > 0;
         rc_fld[BIT_EQ] = int_res == '0;
      end
   end else begin : g_no_rc
      assign rc_fld = '0;
   end

   logic [FIDX_W-1:0] tgt_fld;
   logic [BIDX_W-1:0] tgt_pos;
   assign tgt_fld = tgt_bit[TGT_W-1:BIDX_W];
   assign tgt_pos = tgt_bit[BIDX_W-1:0];

   always_comb begin
      we_a   = '0;
      wd_a   = '0;
      int_we = 1'b0;
      int_wd = '0;
      unique case (op)
         OP_F2I: begin
            int_we = 1'b1;
            int_wd = int_res;
            if (rc && RC_FLAGS) begin
               we_a[0] = '1;
               wd_a[0] = rc_fld;
            end
         end
         OP_F2B: begin
            we_a[tgt_fld][tgt_pos] = 1'b1;
            wd_a[tgt_fld][tgt_pos] = reduced;
         end
         default: begin
            we_a[dst_fld] = '1;
            wd_a[dst_fld] = new_fld;
         end
      endcase
   end

   // assertions beside the decode and merge paths
   always_comb begin
      if (!$isunknown({op_sel, merge_m, mask, mode, rc, src_fld, dst_fld, tgt_bit, int_idx, int_src, cr_in})) begin
         a_r8_single_bit: assert (op != OP_F2B || $countones(cr_we) == 1)
            else $error("a_r8_single_bit");
         a_r9_int_only_f2i: assert (int_we == (op == OP_F2I))
            else $error("a_r9_int_only_f2i");
         a_r2_upper_zero: assert (!int_we || int_wd[XLEN-1:1] == '0)
            else $error("a_r2_upper_zero");
         a_r3_flag_onehot: assert (!(op == OP_F2I && rc && RC_FLAGS) || $onehot(cr_wd[2:0]))
            else $error("a_r3_flag_onehot");
         a_r9_field_enable: assert (!(op == OP_I2F || op == OP_F2F) || $countones(cr_we) == FIELD_W)
            else $error("a_r9_field_enable");
         a_r4_zero_index: assert (!(op == OP_I2F && int_idx == '0 && !merge_m) || wd_a[dst_fld] == (mask & ~mode))
            else $error("a_r4_zero_index");
         for (int i = 0; i < FIELD_W; i++) begin
            if ((op == OP_I2F || (op == OP_F2F && !rc)) && !mask[i]) begin
               a_r5_keep_or_clear: assert (wd_a[dst_fld][i] == (merge_m & file_in[dst_fld][i]))
                  else $error("a_r5_keep_or_clear");
            end
            if (op == OP_F2F && rc && !mask[i]) begin
               a_r7_move_unmasked: assert (wd_a[dst_fld][i] == ((merge_m & file_in[dst_fld][i]) ^ mode[i]))
                  else $error("a_r7_move_unmasked");
            end
         end
      end
   end
endmodule

// File: tb/crml_unit_tb.sv
module crml_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [1:0]  op_sel;
   logic        merge_m, rc;
   logic [3:0]  mask, mode;
   logic [2:0]  src_fld, dst_fld;
   logic [4:0]  tgt_bit, int_idx;
   logic [63:0] int_src;
   logic [31:0] cr_in, cr_we, cr_wd;
   logic        int_we;
   logic [63:0] int_wd;

   crml_unit u_dut (
      .op_sel(op_sel), .merge_m(merge_m), .mask(mask), .mode(mode), .rc(rc),
      .src_fld(src_fld), .dst_fld(dst_fld), .tgt_bit(tgt_bit), .int_idx(int_idx),
      .int_src(int_src), .cr_in(cr_in), .cr_we(cr_we), .cr_wd(cr_wd),
      .int_we(int_we), .int_wd(int_wd)
   );

   typedef struct {
      logic [31:0] we;
      logic [31:0] wd;
      logic        iwe;
      logic [63:0] iwd;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   // independent model written from the requirements
   function automatic exp_t model(logic [1:0] o, logic m, logic [3:0] mk, logic [3:0] md,
                                  logic r, logic [2:0] s, logic [2:0] d, logic [4:0] t,
                                  logic [4:0] ix, logic [63:0] is, logic [31:0] cr, string tag);
      exp_t e;
      logic [3:0] sf, of, tv, nf;
      logic red, lsb;
      e.we = '0; e.wd = '0; e.iwe = 0; e.iwd = '0; e.tag = tag;
      sf = cr[s*4 +: 4];
      of = cr[d*4 +: 4];
      for (int i = 0; i < 4; i++) tv[i] = mk[i] && (md[i] == sf[i]);
      red = m ? (tv != 0) : (tv == 4'hF);
      case (o)
         2'b00: begin
            e.iwe = 1; e.iwd = {63'd0, red};
            if (r) begin
               e.we[3:0] = 4'hF;
               e.wd[3:0] = red ? 4'b0010 : 4'b0100;
            end
         end
         2'b10: begin
            e.we[t] = 1'b1;
            e.wd[t] = red;
         end
         2'b01: begin
            lsb = (ix == 0) ? 1'b0 : is[0];
            for (int i = 0; i < 4; i++) nf[i] = mk[i] ? (md[i] == lsb) : (m && of[i]);
            e.we[d*4 +: 4] = 4'hF; e.wd[d*4 +: 4] = nf;
         end
         default: begin
            for (int i = 0; i < 4; i++) begin
               if (r) nf[i] = (mk[i] ? sf[i] : (m && of[i])) ^ md[i];
               else   nf[i] = mk[i] ? tv[i] : (m && of[i]);
            end
            e.we[d*4 +: 4] = 4'hF; e.wd[d*4 +: 4] = nf;
         end
      endcase
      return e;
   endfunction

   task automatic drive(logic [1:0] o, logic m, logic [3:0] mk, logic [3:0] md, logic r,
                        logic [2:0] s, logic [2:0] d, logic [4:0] t, logic [4:0] ix,
                        logic [63:0] is, logic [31:0] cr, string tag);
      @(posedge clk);
      #1;
      op_sel = o; merge_m = m; mask = mk; mode = md; rc = r; src_fld = s; dst_fld = d;
      tgt_bit = t; int_idx = ix; int_src = is; cr_in = cr;
      exp_q.push_back(model(o, m, mk, md, r, s, d, t, ix, is, cr, tag));
   endtask

   // monitor: compare one result per cycle, away from the driving edge
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         exp_t e;
         logic [63:0] got_iwd;
         e = exp_q.pop_front();
         got_iwd = int_we ? int_wd : 64'd0;
         n_run++;
         if (cr_we !== e.we || (cr_wd & cr_we) !== e.wd || int_we !== e.iwe || got_iwd !== e.iwd) begin
            n_fail++;
            $display("FAIL %s: got we=%h wd=%h iwe=%b iwd=%h, expected we=%h wd=%h iwe=%b iwd=%h",
                     e.tag, cr_we, cr_wd & cr_we, int_we, got_iwd, e.we, e.wd, e.iwe, e.iwd);
         end
      end
   end

   localparam logic [31:0] FILE_A = 32'h7C3A_95E1;

   initial begin
      op_sel = 0; merge_m = 0; mask = 0; mode = 0; rc = 0; src_fld = 0; dst_fld = 0;
      tgt_bit = 0; int_idx = 0; int_src = 0; cr_in = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // idle inputs after reset: field-to-integer, all terms zero
      drive(2'b00, 0, 4'h0, 4'h0, 0, 0, 0, 0, 0, 0, 0, "R2 reset");
      // R1 / R2: OR and AND reductions
      drive(2'b00, 1, 4'b0101, 4'b0001, 0, 3'd0, 0, 0, 0, 0, FILE_A, "R1 R2 or-hit");
      drive(2'b00, 0, 4'b1111, 4'b0001, 0, 3'd0, 0, 0, 0, 0, FILE_A, "R2 and-all");
      drive(2'b00, 0, 4'b1111, 4'b0011, 0, 3'd0, 0, 0, 0, 0, FILE_A, "R2 and-miss");
      // R3: record flags for result one and zero
      drive(2'b00, 1, 4'b1000, 4'b1000, 1, 3'd1, 0, 0, 0, 0, FILE_A, "R3 flags gt");
      drive(2'b00, 1, 4'b0000, 4'b0000, 1, 3'd1, 0, 0, 0, 0, FILE_A, "R3 flags eq");
      // R4: integer lsb, index-zero forcing
      drive(2'b01, 0, 4'b1010, 4'b0010, 0, 0, 3'd5, 0, 5'd7, 64'h3, FILE_A, "R4 lsb one");
      drive(2'b01, 0, 4'b1010, 4'b0010, 0, 0, 3'd5, 0, 5'd0, 64'h3, FILE_A, "R4 index zero");
      // R5: set and clear idioms via merge
      drive(2'b01, 1, 4'b0110, 4'b0000, 0, 0, 3'd2, 0, 5'd0, 0, FILE_A, "R5 set bits");
      drive(2'b01, 1, 4'b0011, 4'b1111, 0, 0, 3'd7, 0, 5'd0, 0, FILE_A, "R5 clear bits");
      // R6: field logic, merge on and off
      drive(2'b11, 1, 4'b0011, 4'b0101, 0, 3'd3, 3'd6, 0, 0, 0, FILE_A, "R6 R5 keep");
      drive(2'b11, 0, 4'b0011, 4'b0101, 0, 3'd3, 3'd6, 0, 0, 0, FILE_A, "R6 R5 clear");
      // R7: masked move with inversion
      drive(2'b11, 1, 4'b1100, 4'b0101, 1, 3'd1, 3'd4, 0, 0, 0, FILE_A, "R7 move keep");
      drive(2'b11, 0, 4'b1111, 4'b1001, 1, 3'd2, 3'd0, 0, 0, 0, FILE_A, "R7 move invert");
      drive(2'b11, 0, 4'b0000, 4'b0110, 1, 3'd2, 3'd3, 0, 0, 0, FILE_A, "R7 move set");
      // R8: single bit, first and last positions
      drive(2'b10, 1, 4'b0010, 4'b0010, 0, 3'd7, 0, 5'd31, 0, 0, FILE_A, "R8 top bit");
      drive(2'b10, 0, 4'b1111, 4'b1110, 0, 3'd0, 0, 5'd0, 0, 0, FILE_A, "R8 bottom bit");
      drive(2'b10, 0, 4'b0110, 4'b1111, 0, 3'd4, 0, 5'd14, 0, 0, FILE_A, "R8 mid bit");
      // R9: pseudorandom sweep of all forms
      for (int k = 0; k < 80; k++) begin
         drive(2'($urandom), 1'($urandom), 4'($urandom), 4'($urandom), 1'($urandom),
               3'($urandom), 3'($urandom), 5'($urandom), 5'($urandom % 4),
               {$urandom, $urandom}, $urandom, "R9 sweep");
      end
      @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule